// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It owns the switch that feeds the external integrator, the control that holds the integrator at zero, and one counter. It reads the external comparator as a single asynchronous bit. The integrator, comparator and reference are analog parts outside the block.

A start request in the idle state begins a conversion. The conversion runs in this order:

- A short zeroing phase, with the integrator held at zero.
- A fixed-length phase in which the integrator sees the unknown input.
- A de-integration phase against the negative reference. The counter is cleared at its start and is then reused to time how long the integrator takes to return to zero.

The count is gated by the synchronized comparator. When the comparator drops, the count is corrected for the synchronizer delay and latched as the result, and a one-cycle done pulse is raised. If the counter would pass its maximum, the conversion ends instead with an over-range flag.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is held and afterwards until a start, intZero=1, selInput=0, selRef=0, done=0, overRange=0 and result=0.
- R2: A start accepted in idle gives ZERO_CYCLES cycles with intZero=1. It is followed by exactly FIXED_COUNT cycles with selInput=1, selRef=0 and intZero=0.
- R3: After the input phase, selRef=1, intZero=0 and selInput=0, and the counter restarts from zero. It advances once per clock only while the synchronized comparator is high.
- R4: cmpIn passes through a two-stage synchronizer. Let m be the number of de-integration clock edges up to and including the first edge at which cmpIn is sampled low. For m>0 the result is m, and done rises ZERO_CYCLES+FIXED_COUNT+m+3 clock edges after the edge that accepted start.
- R5: If the synchronized comparator is already low in the first de-integration cycle, the conversion ends at once with result 0 and overRange=0.
- R6: done is high for exactly one cycle per conversion. result and overRange change only in the cycle in which done is high, and they hold until the next conversion ends.
- R7: If the counter is at its maximum (2^CNT_W-1) while the synchronized comparator is still high, the conversion ends with overRange=1 and result=0.
- R8: In the done cycle, whether the result is a count or an over-range, intZero=1, selInput=0 and selRef=0.
- R9: A start raised while a conversion is running has no effect: the result and the done timing are those of the conversion already under way.
- R10: With FIXED_COUNT=1000, an input that adds 5 units per cycle and a reference that removes 1 unit per cycle, the result is 5000.
- R11: selInput and selRef are never high together, and intZero is low whenever either of them is high. All three come from registers.
- R12: The largest in-range result is 2^CNT_W-3. An m one greater than that gives an over-range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, honoured only when idle |
| cmpIn | input | 1 | Asynchronous comparator output, high while the integrator is above zero |
| selInput | output | 1 | Connect the unknown input to the integrator |
| selRef | output | 1 | Connect the negative reference to the integrator |
| intZero | output | 1 | Hold the integrator output at zero |
| done | output | 1 | One-cycle pulse when a result is ready |
| result | output | CNT_W | Latched conversion count |
| overRange | output | 1 | Last conversion overflowed the counter |

## Verification
The bench builds the block with its default parameters: FIXED_COUNT=1000, CNT_W=14, ZERO_CYCLES=4 and SYNC_STAGES=2. It pairs the block with an integer integrator model whose reference step is 1000 units against a per-cycle input of up to about 16 thousand units. With a 14-bit counter, both the largest in-range result (16381) and the first over-range case are reached in about 17 thousand cycles each. This lets the full-scale boundary, the 5000-count example, a zero input and a one-count input all be run end to end, together with a start pulse injected mid-conversion.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZERO,
    ST_INTEG,
    ST_DEINT,
    ST_DONE
  } phase_e;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic latchResult;
    logic latchOver;
  } dp_strobe_t;

endpackage

// File: rtl/dsadc_datapath.sv
module dsadc_datapath
  import dsadc_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmpIn,
  input  dp_strobe_t       strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             cntAtMax,
  output logic             cmpSync,
  output logic [CNT_W-1:0] result,
  output logic             overRange
);

  localparam logic [CNT_W-1:0] SYNC_LAG = CNT_W'(SYNC_STAGES);

  logic [SYNC_STAGES-1:0] syncChain;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) syncChain[0] <= 1'b0;
          else        syncChain[0] <= cmpIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) syncChain[gi] <= 1'b0;
          else        syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  assign cmpSync  = syncChain[SYNC_STAGES-1];
  assign cntAtMax = &cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (strobe.cntInc)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result    <= '0;
      overRange <= 1'b0;
    end else if (strobe.latchOver) begin
      result    <= '0;
      overRange <= 1'b1;
    end else if (strobe.latchResult) begin
      result    <= (cnt >= SYNC_LAG) ? (cnt - SYNC_LAG) : '0;
      overRange <= 1'b0;
    end
  end

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int FIXED_COUNT = 1000,
  parameter int ZERO_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt,
  input  logic             cntAtMax,
  input  logic             cmpSync,
  output dp_strobe_t       strobe,
  output logic             selInput,
  output logic             selRef,
  output logic             intZero,
  output logic             done
);

  localparam logic [CNT_W-1:0] FIX_LAST  = CNT_W'(FIXED_COUNT - 1);
  localparam logic [CNT_W-1:0] ZERO_LAST = CNT_W'(ZERO_CYCLES - 1);

  phase_e state, nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          nextState       = ST_ZERO;
          strobe.cntClear = 1'b1;
        end
      end
      ST_ZERO: begin
        if (cnt == ZERO_LAST) begin
          nextState       = ST_INTEG;
          strobe.cntClear = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_INTEG: begin
        if (cnt == FIX_LAST) begin
          nextState       = ST_DEINT;
          strobe.cntClear = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_DEINT: begin
        if (!cmpSync) begin
          nextState          = ST_DONE;
          strobe.latchResult = 1'b1;
        end else if (cntAtMax) begin
          nextState        = ST_DONE;
          strobe.latchOver = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      selInput <= 1'b0;
      selRef   <= 1'b0;
      intZero  <= 1'b1;
      done     <= 1'b0;
    end else begin
      state    <= nextState;
      selInput <= (nextState == ST_INTEG);
      selRef   <= (nextState == ST_DEINT);
      intZero  <= !((nextState == ST_INTEG) || (nextState == ST_DEINT));
      done     <= (nextState == ST_DONE);
    end
  end

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsadc_pkg::*;
#(
  parameter int FIXED_COUNT = 1000,
  parameter int CNT_W       = 14,
  parameter int ZERO_CYCLES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmpIn,
  output logic             selInput,
  output logic             selRef,
  output logic             intZero,
  output logic             done,
  output logic [CNT_W-1:0] result,
  output logic             overRange
);

  dp_strobe_t       strobe;
  logic [CNT_W-1:0] cnt;
  logic             cntAtMax;
  logic             cmpSync;

  dsadc_ctrl #(
    .CNT_W(CNT_W), .FIXED_COUNT(FIXED_COUNT), .ZERO_CYCLES(ZERO_CYCLES)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt(cnt),
    .cntAtMax(cntAtMax), .cmpSync(cmpSync), .strobe(strobe),
    .selInput(selInput), .selRef(selRef), .intZero(intZero), .done(done)
  );

  dsadc_datapath #(
    .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .cmpIn(cmpIn), .strobe(strobe),
    .cnt(cnt), .cntAtMax(cntAtMax), .cmpSync(cmpSync),
    .result(result), .overRange(overRange)
  );

endmodule

// File: rtl/dual_slope_seq_chk.sv
module dual_slope_seq_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             selInput,
  input logic             selRef,
  input logic             intZero,
  input logic             done,
  input logic [CNT_W-1:0] result,
  input logic             overRange
);

  a_r11_switch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (selInput || selRef) |-> (!(selInput && selRef) && !intZero));

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_result_moves_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(result) || !$stable(overRange)) |-> done);

  a_r7_over_reports_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && overRange) |-> (result == '0));

  a_r8_done_switch_parked: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (intZero && !selInput && !selRef));

  a_r3_ref_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selRef) |-> $past(selInput));

  a_r2_input_follows_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selInput) |-> $past(intZero));

endmodule

bind dual_slope_seq dual_slope_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .selInput(selInput), .selRef(selRef),
  .intZero(intZero), .done(done), .result(result), .overRange(overRange)
);

// File: tb/dual_slope_seq_tb_top.sv
`timescale 1ns/1ps
module dual_slope_seq_tb_top;

  localparam int FIX   = 1000;
  localparam int CW    = 14;
  localparam int ZC    = 4;
  localparam int MAXC  = (1 << CW) - 1;
  localparam int REFU  = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic cmpIn = 1'b0;
  logic selInput, selRef, intZero, done, overRange;
  logic [CW-1:0] result;

  longint acc = 0;
  longint vinUnits = 0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    int    res;
    bit    ovr;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  dual_slope_seq #(.FIXED_COUNT(FIX), .CNT_W(CW), .ZERO_CYCLES(ZC), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmpIn(cmpIn),
    .selInput(selInput), .selRef(selRef), .intZero(intZero),
    .done(done), .result(result), .overRange(overRange)
  );

  // integrator and comparator model
  always @(posedge clk) begin
    longint nxt;
    nxt = acc;
    if (intZero)       nxt = 0;
    else if (selInput) nxt = acc + vinUnits;
    else if (selRef)   nxt = acc - REFU;
    acc   <= nxt;
    cmpIn <= (nxt > 0);
  end

  task automatic check(input bit ok, input string req, input string detail);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, detail);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6", "unexpected done pulse, actual done=1 expected none");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check((int'(result) == e.res) && (overRange == e.ovr), e.tag,
              $sformatf("result actual=%0d/ovr=%0b expected=%0d/ovr=%0b",
                        result, overRange, e.res, e.ovr));
      end
    end
  end

  task automatic runConv(input longint vin, input string tag, input bit pokeStart);
    longint m;
    int expRes, lat, c;
    bit expOvr;
    exp_t e;
    m = (FIX * vin + REFU - 1) / REFU;
    if (m == 0) begin
      expRes = 0; expOvr = 0; lat = ZC + FIX + 1;
    end else if (m + 2 > MAXC) begin
      expRes = 0; expOvr = 1; lat = ZC + FIX + MAXC + 1;
    end else begin
      expRes = int'(m); expOvr = 0; lat = ZC + FIX + int'(m) + 3;
    end
    e.res = expRes; e.ovr = expOvr; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    vinUnits = vin;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    c = 0;
    forever begin
      @(posedge clk);
      c++;
      @(negedge clk);
      start = (pokeStart && (c == ZC + FIX / 2)) ? 1'b1 : 1'b0;
      if (c == ZC + 5)
        check(selInput && !selRef && !intZero, "R2",
              $sformatf("input phase sel/ref/zero actual=%0b%0b%0b expected=100",
                        selInput, selRef, intZero));
      if ((m > 0) && (c == ZC + FIX + 2))
        check(selRef && !selInput && !intZero, "R3",
              $sformatf("ref phase sel/ref/zero actual=%0b%0b%0b expected=010",
                        selInput, selRef, intZero));
      if (done) break;
    end
    start = 1'b0;
    check(c == lat, pokeStart ? "R9" : "R4",
          $sformatf("%s done latency actual=%0d expected=%0d", tag, c, lat));
    check(intZero && !selInput && !selRef, "R8",
          $sformatf("done switches sel/ref/zero actual=%0b%0b%0b expected=001",
                    selInput, selRef, intZero));
    @(negedge clk);
    check(!done && (int'(result) == expRes), "R6",
          $sformatf("after done: done=%0b result=%0d expected done=0 result=%0d",
                    done, result, expRes));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000 && !finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected completion earlier", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(intZero && !selInput && !selRef && !done && !overRange && result == '0, "R1",
          $sformatf("in reset zero/sel/ref/done/ovr/res actual=%0b%0b%0b%0b%0b/%0d expected=10000/0",
                    intZero, selInput, selRef, done, overRange, result));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(intZero && !selInput && !selRef && !done && !overRange && result == '0, "R1",
          $sformatf("idle zero/sel/ref/done/ovr/res actual=%0b%0b%0b%0b%0b/%0d expected=10000/0",
                    intZero, selInput, selRef, done, overRange, result));

    runConv(5000, "R10 five-volt example", 1'b0);
    runConv(2500, "R4 half-scale input", 1'b0);
    runConv(0, "R5 zero input", 1'b0);
    runConv(1, "R4 one-count input", 1'b0);
    runConv(7, "R4 seven-count input", 1'b0);
    runConv(333, "R4 small input", 1'b0);
    runConv(3000, "R9 start during conversion", 1'b1);
    runConv(16381, "R12 largest in-range", 1'b0);
    runConv(16382, "R7 over-range", 1'b0);
    check(overRange == 1'b1, "R7",
          $sformatf("over-range flag held actual=%0b expected=1", overRange));
    runConv(1200, "R6 flag cleared by next result", 1'b0);
    check(overRange == 1'b0, "R6",
          $sformatf("over-range flag after good result actual=%0b expected=0", overRange));

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R6",
          $sformatf("pending results actual=%0d expected=0", expQ.size()));
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule